// File: doc/BRIEF.md
# Serial Bootstrap RAM Loader

This block stands in for a boot ROM in a small 8-bit processor system. After power-on it keeps the processor in reset with its bus released. It listens on one asynchronous serial line. Each received byte holds half of a value for one of four internal registers: the upper address byte, the lower address byte, a data byte and a handover register. Every complete data value turns into exactly one RAM write at the current address. The loader drives the address, the data and a low-going write strobe, and it times the strobe so that address and data are settled around it. The host needs to resend the upper address byte only when the page changes, so most bytes cost four serial frames.

A complete write to the handover register ends the load. The processor leaves reset, gets its bus back, and the loader turns off its bus drivers and ignores the line until the next power-on reset. The RAM write-enable gating keeps a loader strobe from reaching memory after that point. A separate processor-only reset input restarts the processor without bringing the loader back.

Top module: `boot_loader`

## Requirements
- R1: Frames are 8N1, least significant bit first, one bit every CLK_HZ/BAUD clocks. In a received byte, bits [3:0] are a nibble, bits [6:4] select a register (0 upper address, 1 lower address, 2 data, 3 handover), and bit 7 gives the nibble position (0 = upper nibble, 1 = lower nibble).
- R2: A register takes a new value {upper, lower} only when a position-1 frame follows a position-0 frame for the same select. A position-1 frame with nothing pending is ignored. A repeated position-0 frame replaces the pending upper nibble. Frames for other selects in between disturb nothing.
- R3: Each completed data value causes exactly one RAM write at address {upper byte, lower byte}. The address bytes keep their values across writes.
- R4: The loader's write strobe is low for exactly STROBE_CLKS (2) clocks. mem_addr and mem_data carry the write's values for at least one clock before the strobe and one clock after it.
- R5: A frame whose stop bit reads 0 is discarded, and any pending upper nibble for the select it carries is cleared.
- R6: ram_we_n is the AND of cpu_rw and (loader strobe OR loading finished). A low cpu_rw always reaches ram_we_n.
- R7: From power-on reset until handover: cpu_rst_n = 0, cpu_be = 0, bus_drive = 1.
- R8: A completed handover-register value sets cpu_rst_n = 1, cpu_be = 1 and bus_drive = 0. From then on, serial frames cause no RAM write.
- R9: cpu_rst_req_n low drives cpu_rst_n low one clock later for as long as it is held, and it leaves cpu_be and the locked-out loader unchanged. por_n low re-arms the loader and returns to the R7 state.
- R10: Frames with select codes 4 to 7 change no register and cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on / full reset, active low, re-arms the loader |
| cpu_rst_req_n | input | 1 | Processor-only reset request, active low |
| rx | input | 1 | Asynchronous serial input, idle high |
| cpu_rw | input | 1 | Processor read/write line, low = write |
| mem_addr | output | 16 | Loader address onto the memory bus |
| mem_data | output | 8 | Loader data onto the memory bus |
| bus_drive | output | 1 | High while the loader drives address and data |
| ram_we_n | output | 1 | Gated RAM write enable, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_be | output | 1 | Processor bus enable |

## Verification
The bench builds the loader with CLK_HZ = 800 and BAUD = 100, which gives eight clocks per bit. A full frame then takes 80 clocks, and a run covers dozens of frames, bad-stop frames, out-of-order nibbles and interleaved selects. The strobe and setup/hold settings stay at their defaults, so the bench measures the exact two-clock strobe and the one-clock margins on each side at the RAM pins. Handover, lockout, processor-only reset and re-arming by power-on reset all fall inside the same short run.

// File: rtl/boot_pkg.sv
package boot_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NIB_W     = 4;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned ADDR_W    = 2 * BYTE_W;
    localparam int unsigned NUM_REGS  = 4;
    localparam int unsigned DATA_REGS = NUM_REGS - 1;
    localparam int unsigned SEL_LSB   = NIB_W;
    localparam int unsigned POS_BIT   = BYTE_W - 1;

    localparam logic [SEL_W-1:0] SEL_AHI = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ALO = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DAT = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTL = 3'd3;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
    typedef enum logic [1:0] {WR_IDLE, WR_SETUP, WR_STROBE, WR_HOLD} wr_state_e;
endpackage

// File: rtl/boot_rx.sv
module boot_rx
    import boot_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 93
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              rx_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT);
    localparam int unsigned HALF  = CLKS_PER_BIT / 2;
    localparam int unsigned IDX_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [2:0]        sync;
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] shreg;
        logic              valid;
        logic              err;
    } rx_t;

    rx_t q, d;
    logic line, fall;

    assign line = q.sync[1];
    assign fall = q.sync[2] & ~q.sync[1];

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.err   = 1'b0;
        d.sync  = {q.sync[1:0], rx_i};
        unique case (q.state)
            RX_IDLE: begin
                d.cnt = '0;
                if (fall) d.state = RX_START;
            end
            RX_START: begin
                if (q.cnt == CNT_W'(HALF - 1)) begin
                    d.cnt   = '0;
                    d.idx   = '0;
                    d.state = line ? RX_IDLE : RX_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (q.cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
                    d.cnt   = '0;
                    d.shreg = {line, q.shreg[BYTE_W-1:1]};
                    if (q.idx == IDX_W'(BYTE_W - 1)) d.state = RX_STOP;
                    else                             d.idx   = q.idx + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (q.cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
                    d.cnt   = '0;
                    d.valid = line;
                    d.err   = ~line;
                    d.state = RX_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.state = RX_IDLE;
        endcase
        if (!enable_i) begin
            d.state = RX_IDLE;
            d.valid = 1'b0;
            d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sync  <= '1;
            q.state <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign byte_o  = q.shreg;
    assign valid_o = q.valid;
    assign err_o   = q.err;

    AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o)); // R5
endmodule

// File: rtl/boot_regs.sv
module boot_regs
    import boot_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [BYTE_W-1:0]                    byte_i,
    input  logic                                 valid_i,
    input  logic                                 err_i,
    output logic [DATA_REGS-1:0][BYTE_W-1:0]     regs_o,
    output logic [NUM_REGS-1:0]                  load_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0]                  pend;
        logic [NUM_REGS-1:0][NIB_W-1:0]       upper;
        logic [DATA_REGS-1:0][BYTE_W-1:0]     val;
        logic [NUM_REGS-1:0]                  load;
    } regs_t;

    regs_t q, d;

    logic [SEL_W-1:0]    sel;
    logic [NIB_W-1:0]    nib;
    logic                pos;
    logic [NUM_REGS-1:0] hit;

    assign sel = byte_i[SEL_LSB +: SEL_W];
    assign nib = byte_i[NIB_W-1:0];
    assign pos = byte_i[POS_BIT];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
        assign hit[k] = (sel == SEL_W'(k));
    end

    always_comb begin
        d      = q;
        d.load = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit[k] && valid_i) begin
                if (!pos) begin
                    d.pend[k]  = 1'b1;
                    d.upper[k] = nib;
                end else if (q.pend[k]) begin
                    d.pend[k] = 1'b0;
                    d.load[k] = 1'b1;
                end
            end
            if (hit[k] && err_i) d.pend[k] = 1'b0;
        end
        for (int k = 0; k < DATA_REGS; k++) begin
            if (hit[k] && valid_i && pos && q.pend[k]) d.val[k] = {q.upper[k], nib};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign regs_o = q.val;
    assign load_o = q.load;

    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_o)); // R2
endmodule

// File: rtl/boot_wr.sv
module boot_wr
    import boot_pkg::*;
#(
    parameter int unsigned STROBE_CLKS = 2,
    parameter int unsigned SETUP_CLKS  = 1,
    parameter int unsigned HOLD_CLKS   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              we_n_o,
    output logic              busy_o
);
    localparam int unsigned MAX_A = (STROBE_CLKS > SETUP_CLKS) ? STROBE_CLKS : SETUP_CLKS;
    localparam int unsigned MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
    localparam int unsigned CNT_W = $clog2(MAX_C + 1);

    typedef struct packed {
        wr_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic              we_n;
    } wr_t;

    wr_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            WR_IDLE: begin
                d.cnt = '0;
                if (start_i) begin
                    d.addr  = addr_i;
                    d.data  = data_i;
                    d.state = WR_SETUP;
                end
            end
            WR_SETUP: begin
                if (q.cnt == CNT_W'(SETUP_CLKS - 1)) begin
                    d.cnt   = '0;
                    d.state = WR_STROBE;
                end else d.cnt = q.cnt + 1'b1;
            end
            WR_STROBE: begin
                if (q.cnt == CNT_W'(STROBE_CLKS - 1)) begin
                    d.cnt   = '0;
                    d.state = WR_HOLD;
                end else d.cnt = q.cnt + 1'b1;
            end
            WR_HOLD: begin
                if (q.cnt == CNT_W'(HOLD_CLKS - 1)) begin
                    d.cnt   = '0;
                    d.state = WR_IDLE;
                end else d.cnt = q.cnt + 1'b1;
            end
            default: d.state = WR_IDLE;
        endcase
        if (!enable_i) d.state = WR_IDLE;
        d.we_n = ~(d.state == WR_STROBE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= WR_IDLE;
            q.we_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign addr_o = q.addr;
    assign data_o = q.data;
    assign we_n_o = q.we_n;
    assign busy_o = (q.state != WR_IDLE);

    logic [CNT_W:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      low_run <= '0;
        else if (!q.we_n) low_run <= low_run + 1'b1;
        else             low_run <= '0;
    end

    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> (low_run == (CNT_W+1)'(STROBE_CLKS))); // R4
    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n_o || $rose(we_n_o)) |-> ($stable(addr_o) && $stable(data_o))); // R4
endmodule

// File: rtl/boot_loader.sv
module boot_loader
    import boot_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 1_800_000,
    parameter int unsigned BAUD        = 19_200,
    parameter int unsigned STROBE_CLKS = 2,
    parameter int unsigned SETUP_CLKS  = 1,
    parameter int unsigned HOLD_CLKS   = 1
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        cpu_rst_req_n,
    input  logic        rx,
    input  logic        cpu_rw,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_data,
    output logic        bus_drive,
    output logic        ram_we_n,
    output logic        cpu_rst_n,
    output logic        cpu_be
);
    localparam int unsigned CLKS_PER_BIT = CLK_HZ / BAUD;

    typedef struct packed {
        logic done;
        logic go_pend;
        logic rst_n;
        logic be;
    } top_t;

    top_t q, d;

    logic [BYTE_W-1:0]                rx_byte;
    logic                             rx_valid, rx_err;
    logic [DATA_REGS-1:0][BYTE_W-1:0] regs;
    logic [NUM_REGS-1:0]              loads;
    logic                             wr_we_n, wr_busy;
    logic [ADDR_W-1:0]                wr_addr;
    logic [BYTE_W-1:0]                wr_data;

    boot_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk      (clk),
        .rst_n    (por_n),
        .enable_i (~q.done),
        .rx_i     (rx),
        .byte_o   (rx_byte),
        .valid_o  (rx_valid),
        .err_o    (rx_err)
    );

    boot_regs u_regs (
        .clk     (clk),
        .rst_n   (por_n),
        .byte_i  (rx_byte),
        .valid_i (rx_valid),
        .err_i   (rx_err),
        .regs_o  (regs),
        .load_o  (loads)
    );

    boot_wr #(
        .STROBE_CLKS (STROBE_CLKS),
        .SETUP_CLKS  (SETUP_CLKS),
        .HOLD_CLKS   (HOLD_CLKS)
    ) u_wr (
        .clk      (clk),
        .rst_n    (por_n),
        .enable_i (~q.done),
        .start_i  (loads[SEL_DAT]),
        .addr_i   ({regs[SEL_AHI], regs[SEL_ALO]}),
        .data_i   (regs[SEL_DAT]),
        .addr_o   (wr_addr),
        .data_o   (wr_data),
        .we_n_o   (wr_we_n),
        .busy_o   (wr_busy)
    );

    always_comb begin
        d = q;
        if (loads[SEL_CTL] && !q.done) d.go_pend = 1'b1;
        if (q.go_pend && !wr_busy) begin
            d.done    = 1'b1;
            d.go_pend = 1'b0;
        end
        d.be    = d.done;
        d.rst_n = d.done & cpu_rst_req_n;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr  = wr_addr;
    assign mem_data  = wr_data;
    assign bus_drive = ~q.done;
    assign ram_we_n  = cpu_rw & (wr_we_n | q.done);
    assign cpu_rst_n = q.rst_n;
    assign cpu_be    = q.be;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        $past(q.done) |-> q.done); // R8
    AST_NO_STROBE_AFTER: assert property (@(posedge clk) disable iff (!por_n)
        q.done |-> wr_we_n); // R8
    AST_CPU_HELD: assert property (@(posedge clk) disable iff (!por_n)
        !q.done |-> (!cpu_rst_n && !cpu_be && bus_drive)); // R7
    AST_REQ_RESETS: assert property (@(posedge clk) disable iff (!por_n)
        !$past(cpu_rst_req_n) |-> !cpu_rst_n); // R9
endmodule

// File: tb/boot_loader_tb.sv
module boot_loader_tb;
    localparam int BIT = 8;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        cpu_rst_req_n = 1'b1;
    logic        rx = 1'b1;
    logic        cpu_rw = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        bus_drive, ram_we_n, cpu_rst_n, cpu_be;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    boot_loader #(.CLK_HZ(800), .BAUD(100)) u_dut (
        .clk(clk), .por_n(por_n), .cpu_rst_req_n(cpu_rst_req_n), .rx(rx),
        .cpu_rw(cpu_rw), .mem_addr(mem_addr), .mem_data(mem_data),
        .bus_drive(bus_drive), .ram_we_n(ram_we_n), .cpu_rst_n(cpu_rst_n),
        .cpu_be(cpu_be)
    );

    // write logger at the RAM pins
    int          wr_count = 0;
    logic [15:0] last_addr = '0, prev_addr = '0;
    logic [7:0]  last_data = '0, prev_data = '0;
    int          run = 0, last_width = 0;
    bit          prev_we = 1'b1, setup_ok = 1'b1, hold_ok = 1'b1, stable_ok = 1'b1;

    always @(negedge clk) begin
        if (prev_we && !ram_we_n) begin
            wr_count++;
            last_addr = mem_addr;
            last_data = mem_data;
            setup_ok  = (prev_addr == mem_addr) && (prev_data == mem_data);
            stable_ok = 1'b1;
            run       = 1;
        end else if (!ram_we_n) begin
            run++;
            if (mem_addr != last_addr || mem_data != last_data) stable_ok = 1'b0;
        end else if (!prev_we && ram_we_n) begin
            last_width = run;
            hold_ok    = (mem_addr == last_addr) && (mem_data == last_data);
        end
        prev_we   = ram_we_n;
        prev_addr = mem_addr;
        prev_data = mem_data;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit stop_ok);
        logic [9:0] f;
        f = {stop_ok, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rx = f[i];
            repeat (BIT) @(negedge clk);
        end
        rx = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic send_half(input logic [2:0] sel, input bit pos, input logic [3:0] nib);
        send_byte({pos, sel, nib}, 1'b1);
    endtask

    task automatic send_reg(input logic [2:0] sel, input logic [7:0] v);
        send_half(sel, 1'b0, v[7:4]);
        send_half(sel, 1'b1, v[3:0]);
    endtask

    task automatic do_por();
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check(cpu_rst_n == 0, "R7 reset cpu_rst_n", cpu_rst_n, 0);
        check(cpu_be == 0, "R7 reset cpu_be", cpu_be, 0);
        check(bus_drive == 1, "R7 reset bus_drive", bus_drive, 1);
        check(ram_we_n == 1, "R6 reset ram_we_n", ram_we_n, 1);
    endtask

    task automatic t_basic_write();
        int c0 = wr_count;
        send_reg(3'd0, 8'h12);
        send_reg(3'd1, 8'h34);
        send_reg(3'd2, 8'h56);
        check(wr_count == c0 + 1, "R3 one write", wr_count - c0, 1);
        check(last_addr == 16'h1234, "R1 R3 address", last_addr, 16'h1234);
        check(last_data == 8'h56, "R3 data", last_data, 8'h56);
        check(last_width == 2, "R4 strobe width", last_width, 2);
        check(setup_ok && stable_ok && hold_ok, "R4 setup/hold", {setup_ok, stable_ok, hold_ok}, 3'b111);
    endtask

    task automatic t_page_kept();
        int c0 = wr_count;
        send_reg(3'd1, 8'h35);
        send_reg(3'd2, 8'hA7);
        check(wr_count == c0 + 1, "R3 four-frame write", wr_count - c0, 1);
        check(last_addr == 16'h1235, "R3 upper kept", last_addr, 16'h1235);
        check(last_data == 8'hA7, "R3 data 2", last_data, 8'hA7);
    endtask

    task automatic t_order();
        int c0 = wr_count;
        send_half(3'd2, 1'b1, 4'h9);
        check(wr_count == c0, "R2 lone lower ignored", wr_count - c0, 0);
        send_half(3'd2, 1'b0, 4'h1);
        send_half(3'd2, 1'b0, 4'hC);
        send_half(3'd2, 1'b1, 4'h3);
        check(wr_count == c0 + 1, "R2 restart one write", wr_count - c0, 1);
        check(last_data == 8'hC3, "R2 upper replaced", last_data, 8'hC3);
    endtask

    task automatic t_interleave();
        int c0 = wr_count;
        send_half(3'd2, 1'b0, 4'hE);
        send_half(3'd1, 1'b0, 4'h8);
        send_half(3'd1, 1'b1, 4'h0);
        check(wr_count == c0, "R2 no early write", wr_count - c0, 0);
        send_half(3'd2, 1'b1, 4'h4);
        check(wr_count == c0 + 1, "R2 interleave write", wr_count - c0, 1);
        check(last_addr == 16'h1280 && last_data == 8'hE4, "R2 interleave values",
              {last_addr, last_data}, {16'h1280, 8'hE4});
    endtask

    task automatic t_bad_stop();
        int c0 = wr_count;
        send_half(3'd2, 1'b0, 4'h5);
        send_byte({1'b1, 3'd2, 4'hF}, 1'b0);
        send_half(3'd2, 1'b1, 4'h6);
        check(wr_count == c0, "R5 bad stop cleared", wr_count - c0, 0);
        send_reg(3'd2, 8'h66);
        check(wr_count == c0 + 1 && last_data == 8'h66, "R5 recovery", last_data, 8'h66);
    endtask

    task automatic t_unused_sel();
        int c0 = wr_count;
        send_reg(3'd5, 8'h77);
        send_reg(3'd7, 8'h11);
        check(wr_count == c0, "R10 unused select no write", wr_count - c0, 0);
        send_reg(3'd2, 8'h2B);
        check(last_addr == 16'h1280, "R10 address untouched", last_addr, 16'h1280);
    endtask

    task automatic t_cpu_write_gate();
        cpu_rw = 1'b0;
        @(negedge clk);
        check(ram_we_n == 0, "R6 cpu write passes", ram_we_n, 0);
        cpu_rw = 1'b1;
        @(negedge clk);
        check(ram_we_n == 1, "R6 cpu write released", ram_we_n, 1);
    endtask

    task automatic t_handover();
        send_reg(3'd3, 8'h00);
        check(cpu_rst_n == 1, "R8 cpu_rst_n released", cpu_rst_n, 1);
        check(cpu_be == 1, "R8 cpu_be", cpu_be, 1);
        check(bus_drive == 0, "R8 bus released", bus_drive, 0);
    endtask

    task automatic t_lockout();
        int c0 = wr_count;
        send_reg(3'd2, 8'h99);
        check(wr_count == c0, "R8 no loader write", wr_count - c0, 0);
        check(bus_drive == 0 && cpu_be == 1, "R8 still released", bus_drive, 0);
        cpu_rw = 1'b0;
        @(negedge clk);
        check(ram_we_n == 0, "R6 cpu write after handover", ram_we_n, 0);
        cpu_rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_cpu_reset();
        cpu_rst_req_n = 1'b0;
        @(negedge clk);
        check(cpu_rst_n == 0, "R9 cpu reset asserted", cpu_rst_n, 0);
        repeat (3) @(negedge clk);
        check(cpu_rst_n == 0 && cpu_be == 1 && bus_drive == 0, "R9 held, loader off",
              {cpu_rst_n, cpu_be, bus_drive}, 3'b010);
        cpu_rst_req_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cpu_rst_n == 1, "R9 cpu reset released", cpu_rst_n, 1);
        begin
            int c0 = wr_count;
            send_reg(3'd2, 8'h44);
            check(wr_count == c0, "R9 loader not rearmed", wr_count - c0, 0);
        end
    endtask

    task automatic t_rearm();
        int c0;
        do_por();
        check(cpu_rst_n == 0 && cpu_be == 0 && bus_drive == 1, "R9 por rearms",
              {cpu_rst_n, cpu_be, bus_drive}, 3'b001);
        c0 = wr_count;
        send_reg(3'd0, 8'hC0);
        send_reg(3'd1, 8'h01);
        send_reg(3'd2, 8'h5A);
        check(wr_count == c0 + 1 && last_addr == 16'hC001 && last_data == 8'h5A,
              "R3 write after rearm", last_addr, 16'hC001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        por_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic_write();
        t_page_kept();
        t_order();
        t_interleave();
        t_bad_stop();
        t_unused_sel();
        t_cpu_write_gate();
        t_handover();
        t_lockout();
        t_cpu_reset();
        t_rearm();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule